// File: doc/BRIEF.md
# Timer and Interrupt Register Bank

This block is a byte-wide register file with sixteen addresses. It sits on a simple synchronous bus with an address, write data, a write strobe, a read strobe and registered read data. It holds plain storage bytes for two ports, two direction masks, a shift byte, an auxiliary control byte and a peripheral control byte. It also contains two 16-bit down-counters, each with a reload latch, and a seven-bit interrupt flag and enable pair that drives one interrupt line.

Both counters step down on cycles where the `tick` clock enable is high. When a counter passes zero, it raises its flag. The first timer can run one-shot or free-running, and in free-running mode it reloads from its latch on each pass. The second timer is always one-shot. Software loads the latches and counters byte by byte, and the byte order matters. The interrupt output is high whenever a flag is set whose enable is also set.

Top module: `tmr_regbank`

## Requirements
- R1: A write to address 4 or 6 replaces the low byte of the first timer's 16-bit latch (read back at address 6, with the high byte at address 7). The high byte and the counter are left as they were.
- R2: A write to address 5 replaces the latch high byte and loads the first counter with {written byte, latch low byte}. It clears flag bit 6 and arms a one-shot event. The counter bytes read back at addresses 4 (low) and 5 (high).
- R3: A write to address 7 replaces the latch high byte and clears flag bit 6. The counter is not reloaded.
- R4: A write to address 8 stores the second timer's low latch byte and loads the second counter with that byte zero-extended. The counter reads back at addresses 8 (low) and 9 (high).
- R5: A write to address 9 loads the second counter with {written byte, stored low latch byte} and arms it.
- R6: On each cycle with `tick` high, the first counter decrements. A tick at zero is a pass. In one-shot mode (bit 6 of the auxiliary byte at address 11 is 0), the first pass after an arm sets flag bit 6 and the counter wraps to 0xFFFF; later passes set nothing. In free-running mode, every pass sets flag bit 6 and reloads the counter from the latch.
- R7: The second counter decrements on `tick`. Its first pass after an arm sets flag bit 5 and wraps to 0xFFFF. Later passes set nothing.
- R8: A write to address 13 clears each flag bit whose written bit is 1 and leaves the others alone. A counter pass in the same cycle still sets its flag.
- R9: A write to address 14 with bit 7 set ORs bits 6:0 into the enable mask. With bit 7 clear, it clears the mask bits that are 1 in bits 6:0. Reading address 14 returns the mask with bit 7 as 1.
- R10: `irq_o` is the OR over bits 6:0 of flags AND enables. Reading address 13 returns the flags with `irq_o` in bit 7.
- R11: After reset, the first latch and counter are 0xFFFF, the second latch is 0 and its counter is 0xFFFF. Flags, enables, storage bytes and `rdata` are 0, and no timer is armed.
- R12: Addresses 1 and 15 write and read the same port-A byte. Addresses 0, 2, 3, 10, 11 and 12 store and return their own bytes.
- R13: A read strobe captures the addressed value into `rdata` at the next clock edge. `rdata` holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Counter clock enable |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The first timer is run with a counter load of 3 and ticked to one short of the pass and then through it, which tells the zero state apart from the pass. Free-running and one-shot modes use the same latch and the same number of ticks. A free-running second pass must raise the flag again, while a one-shot second pass must not. The high-byte writes at addresses 5 and 7 come after a set flag, which separates a counter reload from a latch-only update. Flag clears and enable updates use masks that cover and miss the live bit, so bit-selective behaviour is told apart from whole-register behaviour.

// File: rtl/tmr_regbank_pkg.sv
package tmr_regbank_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NMISC = 7;
  localparam int T1_FLAG = 6;
  localparam int T2_FLAG = 5;
  localparam int FREERUN_BIT = 6;
  localparam int AUX_IDX = 5;

  typedef enum logic [AW-1:0] {
    RA_PORTB   = 4'd0,
    RA_PORTA_H = 4'd1,
    RA_DIRB    = 4'd2,
    RA_DIRA    = 4'd3,
    RA_T1C_LO  = 4'd4,
    RA_T1C_HI  = 4'd5,
    RA_T1L_LO  = 4'd6,
    RA_T1L_HI  = 4'd7,
    RA_T2C_LO  = 4'd8,
    RA_T2C_HI  = 4'd9,
    RA_SHIFT   = 4'd10,
    RA_AUX     = 4'd11,
    RA_PERIPH  = 4'd12,
    RA_FLAGS   = 4'd13,
    RA_ENABLE  = 4'd14,
    RA_PORTA_N = 4'd15
  } reg_addr_e;

  // storage byte index -> address match (port A has two aliases)
  function automatic logic misc_hit(input int idx, input logic [AW-1:0] a);
    case (idx)
      0:       misc_hit = (a == RA_PORTB);
      1:       misc_hit = (a == RA_PORTA_H) || (a == RA_PORTA_N);
      2:       misc_hit = (a == RA_DIRB);
      3:       misc_hit = (a == RA_DIRA);
      4:       misc_hit = (a == RA_SHIFT);
      5:       misc_hit = (a == RA_AUX);
      6:       misc_hit = (a == RA_PERIPH);
      default: misc_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_reset_sync.sv
module tmr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tmr_t1_unit.sv
module tmr_t1_unit #(
  parameter int DW = 8,
  localparam int TW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_lat_lo,
  input  logic          wr_hi_load,
  input  logic          wr_hi_only,
  input  logic [DW-1:0] wdata,
  input  logic          free_run,
  output logic [TW-1:0] latch,
  output logic [TW-1:0] count,
  output logic          expire
);
  logic [TW-1:0] lat_d, lat_q, cnt_d, cnt_q;
  logic          arm_d, arm_q;

  always_comb begin
    lat_d  = lat_q;
    cnt_d  = cnt_q;
    arm_d  = arm_q;
    expire = 1'b0;
    if (wr_lat_lo) lat_d[DW-1:0] = wdata;
    if (wr_hi_load || wr_hi_only) lat_d[TW-1:DW] = wdata;
    if (tick) begin
      if (cnt_q == '0) begin
        expire = arm_q || free_run;
        if (free_run) begin
          cnt_d = lat_q;
        end else begin
          cnt_d = '1;
          arm_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (wr_hi_load) begin
      cnt_d  = {wdata, lat_q[DW-1:0]};
      arm_d  = 1'b1;
      expire = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '1;
      cnt_q <= '1;
      arm_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

  assign latch = lat_q;
  assign count = cnt_q;
endmodule

// File: rtl/tmr_t2_unit.sv
module tmr_t2_unit #(
  parameter int DW = 8,
  localparam int TW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [TW-1:0] count,
  output logic          expire
);
  logic [DW-1:0] lat_d, lat_q;
  logic [TW-1:0] cnt_d, cnt_q;
  logic          arm_d, arm_q;

  always_comb begin
    lat_d  = lat_q;
    cnt_d  = cnt_q;
    arm_d  = arm_q;
    expire = 1'b0;
    if (tick) begin
      if (cnt_q == '0) begin
        expire = arm_q;
        arm_d  = 1'b0;
        cnt_d  = '1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (wr_lo) begin
      lat_d  = wdata;
      cnt_d  = {{DW{1'b0}}, wdata};
      expire = 1'b0;
    end
    if (wr_hi) begin
      cnt_d  = {wdata, lat_q};
      arm_d  = 1'b1;
      expire = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      cnt_q <= '1;
      arm_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         en_wr,
  input  logic [N:0]   en_data,
  output logic [N-1:0] flags,
  output logic [N-1:0] enables,
  output logic         irq
);
  logic [N-1:0] flg_d, flg_q, ena_d, ena_q;

  always_comb begin
    flg_d = (flg_q & ~clr_vec) | set_vec;
    ena_d = ena_q;
    if (en_wr) begin
      if (en_data[N]) ena_d = ena_q | en_data[N-1:0];
      else            ena_d = ena_q & ~en_data[N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      ena_q <= '0;
    end else begin
      flg_q <= flg_d;
      ena_q <= ena_d;
    end
  end

  assign flags   = flg_q;
  assign enables = ena_q;
  assign irq     = |(flg_q & ena_q);
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
  import tmr_regbank_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW,
  localparam int TW    = 2 * DATA_W,
  localparam int NFLG  = DATA_W - 1,
  localparam int NADDR = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  logic              rst_n_s;
  logic [NADDR-1:0]  wsel;
  logic [DATA_W-1:0] misc_q [NMISC];
  logic [TW-1:0]     t1_lat, t1_cnt, t2_cnt;
  logic              t1_exp, t2_exp;
  logic [NFLG-1:0]   set_vec, clr_vec, flg_q, ier_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  tmr_reset_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign wsel = wr ? (NADDR'(1) << addr) : '0;

  // plain storage bytes
  for (genvar g = 0; g < NMISC; g++) begin : g_misc
    logic [DATA_W-1:0] b_d, b_q;
    always_comb begin
      b_d = b_q;
      if (wr && misc_hit(g, addr)) b_d = wdata;
    end
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) b_q <= '0;
      else          b_q <= b_d;
    end
    assign misc_q[g] = b_q;
  end

  tmr_t1_unit #(.DW(DATA_W)) u_t1 (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .tick       (tick),
    .wr_lat_lo  (wsel[RA_T1C_LO] | wsel[RA_T1L_LO]),
    .wr_hi_load (wsel[RA_T1C_HI]),
    .wr_hi_only (wsel[RA_T1L_HI]),
    .wdata      (wdata),
    .free_run   (misc_q[AUX_IDX][FREERUN_BIT]),
    .latch      (t1_lat),
    .count      (t1_cnt),
    .expire     (t1_exp)
  );

  tmr_t2_unit #(.DW(DATA_W)) u_t2 (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick   (tick),
    .wr_lo  (wsel[RA_T2C_LO]),
    .wr_hi  (wsel[RA_T2C_HI]),
    .wdata  (wdata),
    .count  (t2_cnt),
    .expire (t2_exp)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[T1_FLAG] = t1_exp;
    set_vec[T2_FLAG] = t2_exp;
    clr_vec          = wsel[RA_FLAGS] ? wdata[NFLG-1:0] : '0;
    if (wsel[RA_T1C_HI] || wsel[RA_T1L_HI]) clr_vec[T1_FLAG] = 1'b1;
  end

  tmr_irq_unit #(.N(NFLG)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .en_wr   (wsel[RA_ENABLE]),
    .en_data (wdata),
    .flags   (flg_q),
    .enables (ier_q),
    .irq     (irq_o)
  );

  // read path
  always_comb begin
    case (reg_addr_e'(addr))
      RA_PORTB:               rdata_d = misc_q[0];
      RA_PORTA_H, RA_PORTA_N: rdata_d = misc_q[1];
      RA_DIRB:                rdata_d = misc_q[2];
      RA_DIRA:                rdata_d = misc_q[3];
      RA_T1C_LO:              rdata_d = t1_cnt[DATA_W-1:0];
      RA_T1C_HI:              rdata_d = t1_cnt[TW-1:DATA_W];
      RA_T1L_LO:              rdata_d = t1_lat[DATA_W-1:0];
      RA_T1L_HI:              rdata_d = t1_lat[TW-1:DATA_W];
      RA_T2C_LO:              rdata_d = t2_cnt[DATA_W-1:0];
      RA_T2C_HI:              rdata_d = t2_cnt[TW-1:DATA_W];
      RA_SHIFT:               rdata_d = misc_q[4];
      RA_AUX:                 rdata_d = misc_q[5];
      RA_PERIPH:              rdata_d = misc_q[6];
      RA_FLAGS:               rdata_d = {irq_o, flg_q};
      RA_ENABLE:              rdata_d = {1'b1, ier_q};
      default:                rdata_d = '0;
    endcase
    if (!rd) rdata_d = rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/tmr_regbank_chk.sv
module tmr_regbank_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int TW = 2 * DATA_W,
  localparam int NFLG = DATA_W - 1
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              tick,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [TW-1:0]     t1_lat,
  input logic [TW-1:0]     t1_cnt,
  input logic [TW-1:0]     t2_cnt,
  input logic [NFLG-1:0]   ier_q,
  input logic [NFLG-1:0]   flg_q,
  input logic              irq_o
);
  a_r2_full_load: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr && addr == 4'd5) |=> t1_cnt == {$past(wdata), $past(t1_lat[DATA_W-1:0])});

  a_r3_no_reload: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr && addr == 4'd7 && !tick) |=> $stable(t1_cnt));

  a_r4_zero_ext: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr && addr == 4'd8) |=> t2_cnt == {{DATA_W{1'b0}}, $past(wdata)});

  a_r9_en_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr && addr == 4'd14 && wdata[DATA_W-1]) |=>
      (ier_q & $past(wdata[NFLG-1:0])) == $past(wdata[NFLG-1:0]));

  a_r9_en_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr && addr == 4'd14 && !wdata[DATA_W-1]) |=>
      (ier_q & $past(wdata[NFLG-1:0])) == '0);

  a_r10_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> (ier_q != '0 && flg_q != '0));
endmodule

bind tmr_regbank tmr_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n_s (rst_n_s),
  .tick    (tick),
  .wr      (wr),
  .addr    (addr),
  .wdata   (wdata),
  .t1_lat  (t1_lat),
  .t1_cnt  (t1_cnt),
  .t2_cnt  (t2_cnt),
  .ier_q   (ier_q),
  .flg_q   (flg_q),
  .irq_o   (irq_o)
);

// File: tb/sim_tmr_regbank.sv
`timescale 1ns/1ps
module sim_tmr_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       irq_o;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  tmr_regbank u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
                  .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata), .irq_o(irq_o));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rreg(a, v);
    chk(req, v, exp);
  endtask

  task automatic rchk_flags(input string req, input logic [6:0] exp);
    logic [7:0] v;
    rreg(4'd13, v);
    chk(req, {1'b0, v[6:0]}, {1'b0, exp});
  endtask

  task automatic t_reset;
    chk("R11 rdata", rdata, 8'h00);
    chk("R11 irq", {7'd0, irq_o}, 8'h00);
    rchk("R11 t1 cnt lo", 4'd4, 8'hFF);
    rchk("R11 t1 cnt hi", 4'd5, 8'hFF);
    rchk("R11 t1 lat lo", 4'd6, 8'hFF);
    rchk("R11 t1 lat hi", 4'd7, 8'hFF);
    rchk("R11 t2 cnt lo", 4'd8, 8'hFF);
    rchk("R11 t2 cnt hi", 4'd9, 8'hFF);
    rchk("R11 flags", 4'd13, 8'h00);
    rchk("R11 enables", 4'd14, 8'h80);
    rchk("R11 aux", 4'd11, 8'h00);
  endtask

  task automatic t_t1_writes;
    logic [7:0] v;
    wreg(4'd4, 8'h34);
    rchk("R1 lat lo", 4'd6, 8'h34);
    rchk("R1 lat hi kept", 4'd7, 8'hFF);
    rchk("R1 cnt kept", 4'd4, 8'hFF);
    wreg(4'd6, 8'h35);
    rchk("R1 alias lat lo", 4'd6, 8'h35);
    wreg(4'd5, 8'h12);
    rchk("R2 cnt lo", 4'd4, 8'h35);
    rchk("R2 cnt hi", 4'd5, 8'h12);
    wreg(4'd7, 8'h56);
    rchk("R3 lat hi", 4'd7, 8'h56);
    rchk("R3 cnt hi kept", 4'd5, 8'h12);
    // R13: rdata holds without rd
    @(negedge clk); addr = 4'd7;
    @(negedge clk); v = rdata;
    chk("R13 hold", v, 8'h12);
  endtask

  task automatic t_t1_oneshot_first;
    wreg(4'd4, 8'h03);
    wreg(4'd5, 8'h00);
    ticks(3);
    rchk("R6 at zero", 4'd4, 8'h00);
    rchk_flags("R6 no flag at zero", 7'h00);
    ticks(1);
    rchk_flags("R6 pass flag", 7'h40);
    rchk("R6 wrap lo", 4'd4, 8'hFF);
    rchk("R6 wrap hi", 4'd5, 8'hFF);
    chk("R10 masked irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_irq_masks;
    wreg(4'd14, 8'hC0);
    rchk("R9 set", 4'd14, 8'hC0);
    chk("R10 irq on", {7'd0, irq_o}, 8'h01);
    rchk("R10 flag bit7", 4'd13, 8'hC0);
    wreg(4'd13, 8'h20);
    rchk("R8 other bit no effect", 4'd13, 8'hC0);
    wreg(4'd13, 8'h40);
    rchk("R8 cleared", 4'd13, 8'h00);
    chk("R10 irq off", {7'd0, irq_o}, 8'h00);
    wreg(4'd14, 8'hFF);
    rchk("R9 set all", 4'd14, 8'hFF);
    wreg(4'd14, 8'h05);
    rchk("R9 clear some", 4'd14, 8'hFA);
  endtask

  task automatic t_t1_modes;
    wreg(4'd11, 8'h40);
    rchk("R12 aux", 4'd11, 8'h40);
    wreg(4'd4, 8'h02);
    wreg(4'd5, 8'h00);
    ticks(3);
    rchk_flags("R6 freerun pass", 7'h40);
    rchk("R6 freerun reload", 4'd4, 8'h02);
    wreg(4'd13, 8'h40);
    ticks(3);
    rchk_flags("R6 freerun again", 7'h40);
    wreg(4'd11, 8'h00);
    wreg(4'd5, 8'h00);
    rchk_flags("R2 clears flag", 7'h00);
    rchk("R2 reload lo", 4'd4, 8'h02);
    ticks(3);
    rchk_flags("R6 oneshot pass", 7'h40);
    wreg(4'd7, 8'h00);
    rchk_flags("R3 clears flag", 7'h00);
    rchk("R3 no reload", 4'd4, 8'hFF);
    ticks(3);
    rchk_flags("R6 oneshot silent", 7'h00);
    rchk("R6 oneshot wraps", 4'd4, 8'hFC);
  endtask

  task automatic t_t2;
    wreg(4'd8, 8'h05);
    rchk("R4 cnt lo", 4'd8, 8'h05);
    rchk("R4 cnt hi", 4'd9, 8'h00);
    wreg(4'd9, 8'h00);
    ticks(5);
    rchk_flags("R7 no flag at zero", 7'h00);
    ticks(1);
    rchk_flags("R7 pass flag", 7'h20);
    chk("R10 t2 irq", {7'd0, irq_o}, 8'h01);
    wreg(4'd13, 8'h20);
    wreg(4'd8, 8'h22);
    wreg(4'd9, 8'h01);
    rchk("R5 cnt lo", 4'd8, 8'h22);
    rchk("R5 cnt hi", 4'd9, 8'h01);
  endtask

  task automatic t_storage;
    wreg(4'd15, 8'hA5);
    rchk("R12 porta alias", 4'd1, 8'hA5);
    wreg(4'd1, 8'h3C);
    rchk("R12 porta nh", 4'd15, 8'h3C);
    wreg(4'd0, 8'h11);
    wreg(4'd2, 8'h22);
    wreg(4'd3, 8'h33);
    wreg(4'd10, 8'h44);
    wreg(4'd12, 8'h66);
    rchk("R12 portb", 4'd0, 8'h11);
    rchk("R12 dirb", 4'd2, 8'h22);
    rchk("R12 dira", 4'd3, 8'h33);
    rchk("R12 shift", 4'd10, 8'h44);
    rchk("R12 periph", 4'd12, 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_t1_writes();
    t_t1_oneshot_first();
    t_irq_masks();
    t_t1_modes();
    t_t2();
    t_storage();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule